// File: doc/BRIEF.md
# Repeat-Mode DMA Channel

This block is a single DMA channel that runs one small transfer each time an activation request arrives. A transfer moves one byte or one 16-bit word between a 24-bit memory pointer and a fixed peripheral location. The peripheral location is an 8-bit register placed at the top of the address space, so its upper sixteen address bits are always ones. The kind of request sets the direction. A request tagged as "serial receive data full" reads the peripheral and writes memory. Every other request reads memory and writes the peripheral.

Software programs four registers through a write-only port: the memory pointer, the peripheral address, the block count and a control word. Each transfer is a bus read followed by a bus write. After the write completes, the channel pulses an acknowledge and decrements a working counter. It may also advance the memory pointer. When the counter reaches zero in repeat mode, the pointer and the counter return to their programmed starting values and service continues. This suits streaming a fixed table to an output port in step with a periodic trigger. With repeat mode off, the channel disables itself at the end of the block.

Top module: `dmarep_channel`

## Requirements
- R1: Each accepted request causes exactly one bus read followed by one bus write. The read data is written back unchanged. `bus_word` is 1 for word size (control bit 1 set) and 0 for byte size.
- R2: The peripheral side of every transfer uses address {16'hFFFF, io_address}. The io_address register is at register offset 1, bits [7:0].
- R3: A request with `req_rx`=1 reads the peripheral address and writes the memory pointer. A request with `req_rx`=0 reads the memory pointer and writes the peripheral address.
- R4: Transfers never modify the peripheral address.
- R5: With control bit 2 set, the memory pointer advances after each transfer by 1 for byte size or by 2 for word size. With control bit 2 clear, the pointer stays fixed.
- R6: Writing the count register (offset 2) loads both the initial count and the working counter. Writing the pointer register (offset 0) loads both the working pointer and its reload copy. In repeat mode (control bit 3 set), the working counter decrements once per transfer. When it reaches zero, the pointer and the counter reload and the channel keeps accepting requests.
- R7: An initial count of zero gives a block of 256 transfers.
- R8: With repeat mode off, the channel clears its enable bit at the end of the block and then ignores requests.
- R9: `ack` is high for one cycle, in the cycle after the write completes. A request that arrives while a transfer is in progress is dropped, not queued.
- R10: Requests are accepted only while the enable bit (control bit 0, offset 3) is set. Clearing the enable bit during a transfer lets that transfer finish.
- R11: While `bus_rdy` is low, the current bus cycle holds its address and direction.
- R12: After reset the channel is idle: `bus_valid` and `ack` are low and the enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 pointer, 1 peripheral, 2 count, 3 control |
| reg_wdata | input | 24 | Register write data |
| req | input | 1 | Activation request |
| req_rx | input | 1 | Request comes from a serial receive-full source |
| ack | output | 1 | One-cycle pulse per completed transfer |
| bus_valid | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_word | output | 1 | 1 for a word access, 0 for a byte access |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Completes the current bus cycle |

## Verification
A table-driven run streams word transfers through a three-transfer block with repeat on. The request kind is mixed across the run, so the checks separate correct direction selection from correct pointer stepping and reload. Directed cases cover:
- a fixed byte pointer, which separates the hold setting from the increment setting;
- a block with repeat off, which must stop after the last transfer;
- a zero count, which must run 256 transfers before wrapping;
- requests raised while the channel is busy;
- bus wait states;
- a disable issued in the middle of a transfer.

// File: rtl/dmarep_pkg.sv
package dmarep_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] OFS_PTR  = 2'd0;
  localparam logic [REG_AW-1:0] OFS_PERI = 2'd1;
  localparam logic [REG_AW-1:0] OFS_CNT  = 2'd2;
  localparam logic [REG_AW-1:0] OFS_CTRL = 2'd3;

  localparam int CB_EN   = 0;
  localparam int CB_WORD = 1;
  localparam int CB_INC  = 2;
  localparam int CB_RPT  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dmarep_regs.sv
module dmarep_regs
  import dmarep_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 8,
  parameter int CNT_W  = 8,
  parameter int WD_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WD_W-1:0]   reg_wdata,
  input  logic              xfer_done,
  input  logic              xfer_word,
  output logic [MEM_AW-1:0] ptr_o,
  output logic [IO_AW-1:0]  peri_o,
  output logic              en_o,
  output logic              word_o
);
  localparam logic [CNT_W-1:0]  CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [MEM_AW-1:0] STEP_B  = {{(MEM_AW-1){1'b0}}, 1'b1};
  localparam logic [MEM_AW-1:0] STEP_W  = {{(MEM_AW-2){1'b0}}, 2'b10};

  logic [MEM_AW-1:0] ptr_q, ptr_n, ptr_base_q, ptr_base_n;
  logic [IO_AW-1:0]  peri_q, peri_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_base_q, cnt_base_n, cnt_dec;
  logic              en_q, en_n, word_q, word_n, inc_q, inc_n, rpt_q, rpt_n;
  logic              ptr_wr, peri_wr, cnt_wr, ctrl_wr, ld_en;
  logic [MEM_AW-1:0] ptr_step;

  assign ptr_wr  = reg_we && (reg_addr == OFS_PTR);
  assign peri_wr = reg_we && (reg_addr == OFS_PERI);
  assign cnt_wr  = reg_we && (reg_addr == OFS_CNT);
  assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
  assign ld_en   = reg_we || xfer_done;

  assign cnt_dec  = cnt_q - CNT_ONE;
  assign ptr_step = xfer_word ? STEP_W : STEP_B;

  always_comb begin
    ptr_n      = ptr_q;
    ptr_base_n = ptr_base_q;
    peri_n     = peri_q;
    cnt_n      = cnt_q;
    cnt_base_n = cnt_base_q;
    en_n       = en_q;
    word_n     = word_q;
    inc_n      = inc_q;
    rpt_n      = rpt_q;
    if (xfer_done) begin
      if (cnt_dec == '0) begin
        if (rpt_q) begin
          ptr_n = ptr_base_q;
          cnt_n = cnt_base_q;
        end else begin
          cnt_n = '0;
          en_n  = 1'b0;
          if (inc_q) ptr_n = ptr_q + ptr_step;
        end
      end else begin
        cnt_n = cnt_dec;
        if (inc_q) ptr_n = ptr_q + ptr_step;
      end
    end
    if (ptr_wr) begin
      ptr_n      = reg_wdata[MEM_AW-1:0];
      ptr_base_n = reg_wdata[MEM_AW-1:0];
    end
    if (peri_wr) peri_n = reg_wdata[IO_AW-1:0];
    if (cnt_wr) begin
      cnt_n      = reg_wdata[CNT_W-1:0];
      cnt_base_n = reg_wdata[CNT_W-1:0];
    end
    if (ctrl_wr) begin
      en_n   = reg_wdata[CB_EN];
      word_n = reg_wdata[CB_WORD];
      inc_n  = reg_wdata[CB_INC];
      rpt_n  = reg_wdata[CB_RPT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      ptr_base_q <= '0;
      peri_q     <= '0;
      cnt_q      <= '0;
      cnt_base_q <= '0;
      en_q       <= 1'b0;
      word_q     <= 1'b0;
      inc_q      <= 1'b0;
      rpt_q      <= 1'b0;
    end else if (ld_en) begin
      ptr_q      <= ptr_n;
      ptr_base_q <= ptr_base_n;
      peri_q     <= peri_n;
      cnt_q      <= cnt_n;
      cnt_base_q <= cnt_base_n;
      en_q       <= en_n;
      word_q     <= word_n;
      inc_q      <= inc_n;
      rpt_q      <= rpt_n;
    end
  end

  assign ptr_o  = ptr_q;
  assign peri_o = peri_q;
  assign en_o   = en_q;
  assign word_o = word_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !cnt_wr && cnt_q != CNT_ONE) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R6
  AST_BLOCK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !reg_we && rpt_q && cnt_q == CNT_ONE) |=> (ptr_q == ptr_base_q && cnt_q == cnt_base_q)); // R6
  AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !ctrl_wr && !rpt_q && cnt_q == CNT_ONE) |=> !en_q); // R8
  AST_PERI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !peri_wr |=> $stable(peri_q)); // R4
endmodule

// File: rtl/dmarep_seq.sv
module dmarep_seq
  import dmarep_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_rx,
  input  logic              en,
  input  logic              cfg_word,
  input  logic              bus_rdy,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              phase_wr,
  output logic              dir_rx,
  output logic              xfer_word,
  output logic [DATA_W-1:0] data_o,
  output logic              xfer_done,
  output logic              ack
);
  seq_state_e        st_q, st_n;
  logic              rx_q, rx_n, wd_q, wd_n, ack_q;
  logic [DATA_W-1:0] dat_q, dat_n;
  logic              accept, rd_done, dat_en, cfg_en;

  assign accept  = (st_q == ST_IDLE) && req && en;
  assign rd_done = (st_q == ST_READ) && bus_rdy;
  assign xfer_done = (st_q == ST_WRITE) && bus_rdy;
  assign dat_en  = rd_done;
  assign cfg_en  = accept;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept)    st_n = ST_READ;
      ST_READ:  if (bus_rdy)   st_n = ST_WRITE;
      ST_WRITE: if (bus_rdy)   st_n = ST_IDLE;
      default:                 st_n = ST_IDLE;
    endcase
    rx_n  = req_rx;
    wd_n  = cfg_word;
    dat_n = bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      ack_q <= xfer_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      wd_q <= 1'b0;
    end else if (cfg_en) begin
      rx_q <= rx_n;
      wd_q <= wd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dat_q <= '0;
    else if (dat_en) dat_q <= dat_n;
  end

  assign busy      = (st_q != ST_IDLE);
  assign phase_wr  = (st_q == ST_WRITE);
  assign dir_rx    = rx_q;
  assign xfer_word = wd_q;
  assign data_o    = dat_q;
  assign ack       = ack_q;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R9
  AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WRITE) && bus_rdy) |=> (st_q == ST_IDLE)); // R9
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !en) |=> (st_q == ST_IDLE)); // R10
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && !bus_rdy) |=> $stable(st_q)); // R11
endmodule

// File: rtl/dmarep_addr.sv
module dmarep_addr #(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 8
) (
  input  logic [MEM_AW-1:0] ptr,
  input  logic [IO_AW-1:0]  peri,
  input  logic              dir_rx,
  input  logic              phase_wr,
  output logic [MEM_AW-1:0] addr
);
  localparam int PAD_W = MEM_AW - IO_AW;

  logic [MEM_AW-1:0] peri_full, src_a, dst_a;

  assign peri_full = {{PAD_W{1'b1}}, peri};

  always_comb begin
    if (dir_rx) begin
      src_a = peri_full;
      dst_a = ptr;
    end else begin
      src_a = ptr;
      dst_a = peri_full;
    end
    addr = phase_wr ? dst_a : src_a;
  end
endmodule

// File: rtl/dmarep_channel.sv
module dmarep_channel
  import dmarep_pkg::*;
#(
  parameter int MEM_AW = 24,
  parameter int IO_AW  = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [MEM_AW-1:0] reg_wdata,
  input  logic              req,
  input  logic              req_rx,
  output logic              ack,
  output logic              bus_valid,
  output logic              bus_we,
  output logic              bus_word,
  output logic [MEM_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rdy
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [MEM_AW-1:0] ptr;
  logic [IO_AW-1:0]  peri;
  logic              en, cfg_word, busy, phase_wr, dir_rx, xfer_word, xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dmarep_regs #(
    .MEM_AW(MEM_AW), .IO_AW(IO_AW), .CNT_W(CNT_W), .WD_W(MEM_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .xfer_done(xfer_done), .xfer_word(xfer_word),
    .ptr_o(ptr), .peri_o(peri), .en_o(en), .word_o(cfg_word)
  );

  dmarep_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .req(req), .req_rx(req_rx), .en(en), .cfg_word(cfg_word),
    .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
    .busy(busy), .phase_wr(phase_wr), .dir_rx(dir_rx), .xfer_word(xfer_word),
    .data_o(bus_wdata), .xfer_done(xfer_done), .ack(ack)
  );

  dmarep_addr #(.MEM_AW(MEM_AW), .IO_AW(IO_AW)) u_addr (
    .ptr(ptr), .peri(peri), .dir_rx(dir_rx), .phase_wr(phase_wr), .addr(bus_addr)
  );

  assign bus_valid = busy;
  assign bus_we    = phase_wr;
  assign bus_word  = xfer_word;

  AST_BUS_STALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_valid && !bus_rdy && !reg_we) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we))); // R11
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bus_valid && !(req && en)) |=> !bus_valid); // R1
endmodule

// File: tb/dmarep_channel_tb.sv
module dmarep_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [23:0] reg_wdata = 24'd0;
  logic        req = 1'b0, req_rx = 1'b0;
  logic        ack, bus_valid, bus_we, bus_word;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_rdy = 1'b1;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [15:0] mdl(input logic [23:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A ^ {8'h00, a[23:16]};
  endfunction
  assign bus_rdata = mdl(bus_addr);

  dmarep_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req(req), .req_rx(req_rx), .ack(ack), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
  );

  typedef struct packed { logic rx; logic [23:0] mem; } vec_t;
  localparam vec_t VEC [7] = '{
    '{1'b0, 24'h012340}, '{1'b1, 24'h012342}, '{1'b0, 24'h012344},
    '{1'b0, 24'h012340}, '{1'b1, 24'h012342}, '{1'b1, 24'h012344},
    '{1'b0, 24'h012340}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
  endtask

  // one full transfer with checks on each bus phase
  task automatic xfer(input logic rx, input logic [23:0] mem, input logic [7:0] io,
                      input logic word, input string tag);
    logic [23:0] src, dst;
    src = rx ? {16'hFFFF, io} : mem;
    dst = rx ? mem : {16'hFFFF, io};
    @(negedge clk); req = 1'b1; req_rx = rx;
    @(posedge clk); @(negedge clk); req = 1'b0;
    chk("R1 read phase", {bus_valid, bus_we}, 2'b10);
    chk("R1 size", bus_word, word);
    chk({"R3 source ", tag}, bus_addr, src);
    @(posedge clk); @(negedge clk);
    chk("R1 write phase", {bus_valid, bus_we}, 2'b11);
    chk({"R3 destination ", tag}, bus_addr, dst);
    chk("R2 peripheral high bits", rx ? src[23:8] : dst[23:8], 16'hFFFF);
    chk("R1 data", bus_wdata, mdl(src));
    @(posedge clk); @(negedge clk);
    chk("R9 ack", {ack, bus_valid}, 2'b10);
  endtask

  task automatic expect_idle(input string tag);
    @(negedge clk); req = 1'b1; req_rx = 1'b0;
    @(posedge clk); @(negedge clk); req = 1'b0;
    chk(tag, bus_valid, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(tag, {bus_valid, ack}, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset idle", {bus_valid, ack}, 2'b00);
    expect_idle("R12 enable clear after reset");

    // R10: enable off blocks requests
    wr_reg(2'd0, 24'h012340); wr_reg(2'd1, 24'h80); wr_reg(2'd2, 24'd3);
    wr_reg(2'd3, 24'h6); // word, inc, no enable
    expect_idle("R10 disabled");

    // table: word, increment, repeat, block of 3, mixed request kinds (R5 R6 R4)
    wr_reg(2'd3, 24'hF);
    for (int i = 0; i < 7; i++) xfer(VEC[i].rx, VEC[i].mem, 8'h80, 1'b1, "R6");

    // R5: byte, pointer held
    wr_reg(2'd0, 24'h000050); wr_reg(2'd1, 24'h11); wr_reg(2'd2, 24'd2);
    wr_reg(2'd3, 24'h9);
    for (int i = 0; i < 3; i++) xfer(i[0], 24'h000050, 8'h11, 1'b0, "R5 held");

    // R8: one-shot block of two
    wr_reg(2'd0, 24'h000200); wr_reg(2'd1, 24'h22); wr_reg(2'd2, 24'd2);
    wr_reg(2'd3, 24'h5);
    xfer(1'b0, 24'h000200, 8'h22, 1'b0, "R4");
    xfer(1'b0, 24'h000201, 8'h22, 1'b0, "R4");
    expect_idle("R8 stop after block");

    // R7: zero count means 256
    wr_reg(2'd0, 24'h000100); wr_reg(2'd1, 24'h33); wr_reg(2'd2, 24'd0);
    wr_reg(2'd3, 24'hD);
    for (int i = 0; i < 256; i++) xfer(1'b0, 24'h000100 + 24'(i), 8'h33, 1'b0, "R7");
    xfer(1'b0, 24'h000100, 8'h33, 1'b0, "R7 wrap");

    // R9: request while busy is dropped
    wr_reg(2'd0, 24'h000300); wr_reg(2'd2, 24'd8);
    @(negedge clk); req = 1'b1; req_rx = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk); req = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 ack after busy request", ack, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R9 busy request not queued", bus_valid, 1'b0);
    xfer(1'b0, 24'h000301, 8'h33, 1'b0, "R9 next pointer");

    // R11: wait states
    @(negedge clk); req = 1'b1;
    @(posedge clk); @(negedge clk); req = 1'b0; bus_rdy = 1'b0;
    chk("R11 read addr", bus_addr, 24'h000302);
    @(posedge clk); @(negedge clk);
    chk("R11 read held", {bus_valid, bus_we}, 2'b10);
    chk("R11 addr held", bus_addr, 24'h000302);
    bus_rdy = 1'b1;
    @(posedge clk); @(negedge clk); bus_rdy = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R11 write held", {bus_valid, bus_we, ack}, 3'b110);
    chk("R11 write addr", bus_addr, 24'hFFFF33);
    bus_rdy = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 ack after wait", ack, 1'b1);

    // R10: disable during a transfer
    @(negedge clk); req = 1'b1;
    @(posedge clk); @(negedge clk); req = 1'b0;
    reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 24'h0;
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
    chk("R10 transfer continues", {bus_valid, bus_we}, 2'b11);
    @(posedge clk); @(negedge clk);
    chk("R10 finishes with ack", ack, 1'b1);
    expect_idle("R10 idle after disable");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule